// File: doc/BRIEF.md
# Fixed-Width Truncated Array Multiplier

This block multiplies two unsigned N-bit operands and returns only the upper N bits of the product. It does this without forming the full 2N-bit product. Partial-product bits whose column index (i+j) is below N-1 are never generated. The bits that land exactly in column N-1 are kept as a correction term. That column is summed with the upper columns, so only its carries reach the result. This partly offsets the bias that dropping the low columns introduces.

The summation is a parallel array of rows. Each row adds one operand bit times the other operand into a running N+1-bit accumulator through a ripple chain of half- and full-adder cells. The accumulator covers columns N-1 to 2N-1, and the result is its upper N bits.

The block is purely combinational, with no clock and no reset. Both the row generator and the adder chain come from generate loops, so one description serves every width N of 2 or more. It is intended for datapaths that only need a rounded-down fixed-width product, for example filter taps and image scaling.

Top module: `tmul_fixed_width`

## Requirements
- R1: The result equals floor(S / 2^N), where S is the sum of x_i·y_j·2^(i+j) over all index pairs with i+j >= N-1. Operand bit 0 is the least significant bit, and the result is an unsigned N-bit value.
- R2: The result is never larger than the exact upper half floor(A·B / 2^N). This is inside the allowed bound of the exact upper half plus one LSB.
- R3: The result is never smaller than floor(A·B / 2^N) - (N-1).
- R4: When either operand is zero, the result is zero.
- R5: When both operands are all ones, the result obeys R1 and does not exceed the exact upper N bits plus one LSB.
- R6: The same rule from R1 to R3 holds for N = 4, 6, 8 and 12.
- R7: The N+1-bit accumulator of columns N-1 to 2N-1 never produces a carry out of its top bit in any row addition.
- R8: Exchanging the two operands does not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | Unsigned multiplicand |
| op_b | input | N | Unsigned multiplier |
| prod_hi | output | N | Approximate upper N bits of op_a × op_b |

## Verification
Immediate assertions evaluated on every settled change of the operands check four things against an exact product: the upper and lower error bounds, the zero-operand result, and the absence of any carry out of the accumulator. The bit-exact truncation rule is shown only by the bench's scenarios. Those scenarios compare every result against a column-by-column model: exhaustively for widths 4, 6 and 8, and on random vectors at width 12. Operand symmetry and the all-ones corner are likewise confirmed only by the bench.

// File: rtl/tmul_pkg.sv
package tmul_pkg;
  // Width of the accumulator that holds columns N-1 .. 2N-1.
  function automatic int acc_width(input int n);
    return n + 1;
  endfunction

  // Lowest product column that is formed.
  function automatic int first_col(input int n);
    return n - 1;
  endfunction
endpackage

// File: rtl/tmul_add_cell.sv
module tmul_add_cell #(
  parameter bit FULL = 1'b1
) (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  generate
    if (FULL) begin : g_fa
      assign s  = a ^ b ^ ci;
      assign co = (a & b) | (ci & (a ^ b));
    end else begin : g_ha
      logic unused_ci;
      assign unused_ci = ci;
      assign s  = a ^ b;
      assign co = a & b;
    end
  endgenerate
endmodule

// File: rtl/tmul_row_adder.sv
module tmul_row_adder #(
  parameter int W = 9
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] c;
  assign c[0] = 1'b0;

  generate
    for (genvar k = 0; k < W; k++) begin : g_bit
      tmul_add_cell #(.FULL(k != 0)) u_cell (
        .a (a[k]),
        .b (b[k]),
        .ci(c[k]),
        .s (s[k]),
        .co(c[k+1])
      );
    end
  endgenerate

  assign co = c[W];
endmodule

// File: rtl/tmul_pp_rows.sv
module tmul_pp_rows
  import tmul_pkg::*;
#(
  parameter int N = 8,
  localparam int AW = acc_width(N),
  localparam int C0 = first_col(N)
) (
  input  logic [N-1:0]         x,
  input  logic [N-1:0]         y,
  output logic [N-1:0][AW-1:0] rows
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_row
      for (genvar k = 0; k < AW; k++) begin : g_col
        localparam int J = k + C0 - i;
        if (J >= 0 && J < N) begin : g_pp
          assign rows[i][k] = x[i] & y[J];
        end else begin : g_zero
          assign rows[i][k] = 1'b0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/tmul_fixed_width.sv
module tmul_fixed_width
  import tmul_pkg::*;
#(
  parameter int N = 8,
  localparam int AW = acc_width(N)
) (
  input  logic [N-1:0] op_a,
  input  logic [N-1:0] op_b,
  output logic [N-1:0] prod_hi
);
  logic [N-1:0][AW-1:0] rows;
  logic [N-1:0][AW-1:0] acc;
  logic [N-1:0]         row_co;
  logic                 unused_col_lsb;

  tmul_pp_rows #(.N(N)) u_rows (
    .x   (op_a),
    .y   (op_b),
    .rows(rows)
  );

  assign acc[0]    = rows[0];
  assign row_co[0] = 1'b0;

  generate
    for (genvar i = 1; i < N; i++) begin : g_stage
      tmul_row_adder #(.W(AW)) u_add (
        .a (acc[i-1]),
        .b (rows[i]),
        .s (acc[i]),
        .co(row_co[i])
      );
    end
  endgenerate

  assign prod_hi        = acc[N-1][AW-1:1];
  assign unused_col_lsb = acc[N-1][0];

  // Checks against an exact product, evaluated once the operands are known.
  logic [2*N-1:0] exact_full;
  logic [N-1:0]   exact_hi;
  assign exact_full = {{N{1'b0}}, op_a} * {{N{1'b0}}, op_b};
  assign exact_hi   = exact_full[2*N-1:N];

  always_comb begin
    if (!$isunknown({op_a, op_b, prod_hi, row_co})) begin
      assert_no_overflow_R7: assert (row_co == '0)
        else $error("accumulator carry out");
      assert_upper_bound_R2: assert (prod_hi <= exact_hi)
        else $error("result above exact upper half");
      assert_lower_bound_R3: assert ({1'b0, prod_hi} + (N - 1) >= {1'b0, exact_hi})
        else $error("result below error bound");
      assert_zero_operand_R4: assert (!(op_a == '0 || op_b == '0) || prod_hi == '0)
        else $error("nonzero result for zero operand");
    end
  end
endmodule

// File: tb/tmul_fixed_width_test.sv
module tmul_fixed_width_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [3:0]  a4, b4;   wire [3:0]  r4;
  logic [5:0]  a6, b6;   wire [5:0]  r6;
  logic [7:0]  a8, b8;   wire [7:0]  r8, r8s;
  logic [11:0] a12, b12; wire [11:0] r12;

  tmul_fixed_width #(.N(4))  u4    (.op_a(a4),  .op_b(b4),  .prod_hi(r4));
  tmul_fixed_width #(.N(6))  u6    (.op_a(a6),  .op_b(b6),  .prod_hi(r6));
  tmul_fixed_width #(.N(8))  uut   (.op_a(a8),  .op_b(b8),  .prod_hi(r8));
  tmul_fixed_width #(.N(8))  uswap (.op_a(b8),  .op_b(a8),  .prod_hi(r8s));
  tmul_fixed_width #(.N(12)) u12   (.op_a(a12), .op_b(b12), .prod_hi(r12));

  function automatic longint model(input int n, input longint a, input longint b);
    longint s = 0;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < n; j++)
        if (i + j >= n - 1 && ((a >> i) & 1) == 1 && ((b >> j) & 1) == 1)
          s += longint'(1) << (i + j);
    return s >> n;
  endfunction

  function automatic longint exact_hi(input int n, input longint a, input longint b);
    return (a * b) >> n;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic verify(input int n, input longint a, input longint b, input longint r);
    longint m = model(n, a, b);
    longint e = exact_hi(n, a, b);
    check(r == m, $sformatf("R1 R6 n=%0d a=%0d b=%0d", n, a, b), r, m);
    check(r <= e, $sformatf("R2 n=%0d a=%0d b=%0d", n, a, b), r, e);
    check(r + n - 1 >= e, $sformatf("R3 n=%0d a=%0d b=%0d", n, a, b), r, e);
  endtask

  task automatic apply(input longint v4a, v4b, v6a, v6b, v8a, v8b, v12a, v12b);
    @(posedge clk);
    a4 = 4'(v4a); b4 = 4'(v4b); a6 = 6'(v6a); b6 = 6'(v6b);
    a8 = 8'(v8a); b8 = 8'(v8b); a12 = 12'(v12a); b12 = 12'(v12b);
    @(negedge clk);
  endtask

  initial begin
    int unsigned seed;
    seed = 32'h1d2c3b4a;
    void'($urandom(seed));
    a4 = 0; b4 = 0; a6 = 0; b6 = 0; a8 = 0; b8 = 0; a12 = 0; b12 = 0;

    // R4: zero operands at every width
    apply(0, 9, 0, 45, 0, 200, 0, 3000);
    check(r4 == 0, "R4 n=4", r4, 0);
    check(r6 == 0, "R4 n=6", r6, 0);
    check(r8 == 0, "R4 n=8", r8, 0);
    check(r12 == 0, "R4 n=12", r12, 0);
    apply(13, 0, 60, 0, 255, 0, 4095, 0);
    check(r4 == 0, "R4 n=4 b", r4, 0);
    check(r6 == 0, "R4 n=6 b", r6, 0);
    check(r8 == 0, "R4 n=8 b", r8, 0);
    check(r12 == 0, "R4 n=12 b", r12, 0);

    // R5: both operands all ones
    apply(15, 15, 63, 63, 255, 255, 4095, 4095);
    check(r4 == model(4, 15, 15) && r4 <= exact_hi(4, 15, 15) + 1, "R5 n=4", r4, model(4, 15, 15));
    check(r6 == model(6, 63, 63) && r6 <= exact_hi(6, 63, 63) + 1, "R5 n=6", r6, model(6, 63, 63));
    check(r8 == model(8, 255, 255) && r8 <= exact_hi(8, 255, 255) + 1, "R5 n=8", r8, model(8, 255, 255));
    check(r12 == model(12, 4095, 4095) && r12 <= exact_hi(12, 4095, 4095) + 1, "R5 n=12", r12,
          model(12, 4095, 4095));

    // R6: exhaustive for widths 4, 6, 8; random for width 12; R8 symmetry
    for (int v = 0; v < 65536; v++) begin
      longint ra = longint'($urandom() & 12'hfff);
      longint rb = longint'($urandom() & 12'hfff);
      apply(v & 15, (v >> 4) & 15, v & 63, (v >> 6) & 63, v & 255, (v >> 8) & 255, ra, rb);
      if (v < 256)  verify(4, v & 15, (v >> 4) & 15, longint'(r4));
      if (v < 4096) verify(6, v & 63, (v >> 6) & 63, longint'(r6));
      verify(8, v & 255, (v >> 8) & 255, longint'(r8));
      check(r8 == r8s, $sformatf("R8 a=%0d b=%0d", v & 255, (v >> 8) & 255), r8s, r8);
      if (v < 30000) verify(12, ra, rb, longint'(r12));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule